// File: doc/BRIEF.md
# Symbol-Tagged Word Memory

This block is a word memory in which every data word owns one name tag, so any word can be reached either by its numeric address or by the name stored in its tag. A loader fills it in sessions. While `load_mode` is high, program words go into consecutive addresses starting at zero. A statement name handed in with a program word becomes the tag of that same word. Each variable name handed in claims the next free word counted down from the top address.

Once `load_mode` falls, the contents serve execution with no translation step. A symbolic access compares the presented name with every valid tag in the same cycle and reads or writes the word whose tag matches exactly. A plain access uses the numeric address directly. Results are registered and appear one cycle after the request. Missing names and requests that would make the program area and the variable area collide are reported on single-cycle flags.

Top module: `symtag_mem`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `rd_valid`, `miss` and `ovf` are low.
- R2: The first cycle in which `load_mode` is high after being low (or after reset) starts a session. In that cycle every tag becomes invalid, the program pointer returns to address 0 and the variable pointer returns to address DEPTH-1. Load requests made in that cycle are ignored.
- R3: In a later cycle of the session, each accepted `ld_we` writes `ld_wdata` into the next program address, beginning at 0 and counting up by one.
- R4: When `ld_label_en` is high with an accepted `ld_we`, `ld_label` becomes the valid tag of the word written in that cycle. `ld_label_en` without `ld_we` stores no tag.
- R5: Each accepted `ld_var_en` stores `ld_var_name` as the valid tag of the variable pointer's word. The first variable of a session lands at DEPTH-1, the next at DEPTH-2, and so on.
- R6: A symbolic read (`acc_sym`=1, `acc_we`=0) whose name equals a valid tag in all TAG_W bits raises `rd_valid` in the next cycle, with that word's data on `rd_data`. If several tags match, the lowest address wins.
- R7: A symbolic write (`acc_sym`=1, `acc_we`=1) whose name matches a tag replaces the data of the matched word with `acc_wdata`.
- R8: A symbolic access with no matching valid tag touches no word. It raises `miss` for one cycle, in the cycle after the request, and leaves `rd_valid` low.
- R9: A plain access (`acc_sym`=0) reads or writes the word at `acc_addr`. A plain read raises `rd_valid` with that word's data in the next cycle and never raises `miss`.
- R10: A program write is refused when the program words and the variable words of the session already fill all DEPTH words. A variable is refused when it would land on or below the highest program word, counting a program word accepted in the same cycle. A refused request writes nothing, and `ovf` is high in the next cycle.
- R11: Access requests are ignored while `load_mode` is high. Load requests are ignored while `load_mode` is low. `ovf` is never raised by a cycle in which `load_mode` is low.
- R12: An access made in the first cycle after `load_mode` falls is carried out normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_mode | input | 1 | High: load session, low: execution |
| ld_we | input | 1 | Write a program word at the next program address |
| ld_wdata | input | DATA_W | Program word data |
| ld_label_en | input | 1 | Tag the program word written this cycle |
| ld_label | input | TAG_W | Statement name for that word |
| ld_var_en | input | 1 | Allocate a variable word from the top |
| ld_var_name | input | TAG_W | Variable name |
| acc_en | input | 1 | Access request |
| acc_sym | input | 1 | 1: by name, 0: by address |
| acc_we | input | 1 | 1: write, 0: read |
| acc_addr | input | AW | Numeric address for plain access |
| acc_name | input | TAG_W | Name for symbolic access |
| acc_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after the read) |
| rd_data | output | DATA_W | Read data |
| miss | output | 1 | Symbolic access found no tag |
| ovf | output | 1 | A load request was refused in the previous cycle |

## Verification
Every result of this block arrives one clock edge after the request that causes it. Read data, `rd_valid` and `miss` are registered at the edge that accepts the access, and `ovf` is registered at the edge that refuses the load request. Data and tag writes are visible to any access made in the next cycle. The bench therefore drives each request on the falling edge and samples the flags and data just after the following rising edge. Stored state is checked by a separate access in a later cycle, so no check depends on the order of events within one edge.

// File: rtl/symtag_pkg.sv
package symtag_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_MISS  = 2'd3
  } acc_kind_e;

endpackage

// File: rtl/symtag_load_ctrl.sv
module symtag_load_ctrl #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_mode,
  input  logic          prog_req,
  input  logic          var_req,
  output logic          sess_clr,
  output logic          prog_ok,
  output logic [AW-1:0] prog_addr,
  output logic          var_ok,
  output logic [AW-1:0] var_addr,
  output logic          ovf
);

  localparam int CW = AW + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [AW-1:0] TOP_C   = AW'(DEPTH - 1);

  logic          lm_q;
  logic [CW-1:0] pcnt_q, pcnt_n;
  logic [CW-1:0] vcnt_q, vcnt_n;
  logic          ovf_q, ovf_n;
  logic          active;
  logic [CW-1:0] used;
  logic [CW-1:0] used_after;
  logic          refuse;

  always_comb begin
    sess_clr   = load_mode & ~lm_q;
    active     = load_mode & lm_q;
    used       = pcnt_q + vcnt_q;
    prog_ok    = active & prog_req & (used < DEPTH_C);
    used_after = used + CW'(prog_ok);
    var_ok     = active & var_req & (used_after < DEPTH_C);
    refuse     = (active & prog_req & ~prog_ok) | (active & var_req & ~var_ok);
    prog_addr  = pcnt_q[AW-1:0];
    var_addr   = TOP_C - vcnt_q[AW-1:0];
  end

  always_comb begin
    pcnt_n = pcnt_q;
    vcnt_n = vcnt_q;
    if (sess_clr) begin
      pcnt_n = '0;
      vcnt_n = '0;
    end else begin
      if (prog_ok) pcnt_n = pcnt_q + CW'(1);
      if (var_ok)  vcnt_n = vcnt_q + CW'(1);
    end
    ovf_n = refuse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lm_q   <= 1'b0;
      pcnt_q <= '0;
      vcnt_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      lm_q   <= load_mode;
      pcnt_q <= pcnt_n;
      vcnt_q <= vcnt_n;
      ovf_q  <= ovf_n;
    end
  end

  assign ovf = ovf_q;

endmodule

// File: rtl/symtag_tag_cam.sv
module symtag_tag_cam #(
  parameter int DEPTH = 64,
  parameter int TAG_W = 36,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wa_en,
  input  logic [AW-1:0]    wa_idx,
  input  logic [TAG_W-1:0] wa_tag,
  input  logic             wb_en,
  input  logic [AW-1:0]    wb_idx,
  input  logic [TAG_W-1:0] wb_tag,
  input  logic [TAG_W-1:0] key,
  output logic             hit,
  output logic [AW-1:0]    hit_idx
);

  logic [DEPTH-1:0] match;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic             vld_q, vld_n;
    logic [TAG_W-1:0] tag_q, tag_n;
    logic             tag_en;
    logic             sel_a, sel_b;

    always_comb begin
      sel_a  = wa_en & (wa_idx == AW'(g));
      sel_b  = wb_en & (wb_idx == AW'(g));
      tag_en = ~clr & (sel_a | sel_b);
      tag_n  = sel_a ? wa_tag : wb_tag;
      if (clr)         vld_n = 1'b0;
      else if (tag_en) vld_n = 1'b1;
      else             vld_n = vld_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= vld_n;
    end

    always_ff @(posedge clk) begin
      if (tag_en) tag_q <= tag_n;
    end

    assign match[g] = vld_q & (tag_q == key);
  end

  always_comb begin
    hit     = |match;
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = AW'(i);
    end
  end

endmodule

// File: rtl/symtag_data_ram.sv
module symtag_data_ram #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 12,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/symtag_mem.sv
module symtag_mem
  import symtag_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 64,
  parameter int TAG_W  = 36,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_mode,
  input  logic              ld_we,
  input  logic [DATA_W-1:0] ld_wdata,
  input  logic              ld_label_en,
  input  logic [TAG_W-1:0]  ld_label,
  input  logic              ld_var_en,
  input  logic [TAG_W-1:0]  ld_var_name,
  input  logic              acc_en,
  input  logic              acc_sym,
  input  logic              acc_we,
  input  logic [AW-1:0]     acc_addr,
  input  logic [TAG_W-1:0]  acc_name,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              miss,
  output logic              ovf
);

  logic          sess_clr;
  logic          prog_ok;
  logic [AW-1:0] prog_addr;
  logic          var_ok;
  logic [AW-1:0] var_addr;
  logic          hit;
  logic [AW-1:0] hit_idx;

  acc_kind_e         kind;
  logic [AW-1:0]     tgt_addr;
  logic              ram_we;
  logic [AW-1:0]     ram_waddr;
  logic [DATA_W-1:0] ram_wdata;
  logic              ram_re;
  logic              rdv_q, rdv_n;
  logic              miss_q, miss_n;

  symtag_load_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_mode (load_mode),
    .prog_req  (ld_we),
    .var_req   (ld_var_en),
    .sess_clr  (sess_clr),
    .prog_ok   (prog_ok),
    .prog_addr (prog_addr),
    .var_ok    (var_ok),
    .var_addr  (var_addr),
    .ovf       (ovf)
  );

  symtag_tag_cam #(.DEPTH(DEPTH), .TAG_W(TAG_W), .AW(AW)) u_cam (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (sess_clr),
    .wa_en   (prog_ok & ld_label_en),
    .wa_idx  (prog_addr),
    .wa_tag  (ld_label),
    .wb_en   (var_ok),
    .wb_idx  (var_addr),
    .wb_tag  (ld_var_name),
    .key     (acc_name),
    .hit     (hit),
    .hit_idx (hit_idx)
  );

  // Classify the access of this cycle
  always_comb begin
    kind = ACC_IDLE;
    if (acc_en && !load_mode) begin
      if (acc_sym && !hit) kind = ACC_MISS;
      else if (acc_we)     kind = ACC_WRITE;
      else                 kind = ACC_READ;
    end
    tgt_addr = acc_sym ? hit_idx : acc_addr;
  end

  // Single data write port shared by loader and execution
  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = prog_addr;
    ram_wdata = ld_wdata;
    if (prog_ok) begin
      ram_we = 1'b1;
    end else if (kind == ACC_WRITE) begin
      ram_we    = 1'b1;
      ram_waddr = tgt_addr;
      ram_wdata = acc_wdata;
    end
    ram_re = (kind == ACC_READ);
  end

  symtag_data_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .re    (ram_re),
    .raddr (tgt_addr),
    .rdata (rd_data)
  );

  always_comb begin
    rdv_n  = (kind == ACC_READ);
    miss_n = (kind == ACC_MISS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdv_q  <= 1'b0;
      miss_q <= 1'b0;
    end else begin
      rdv_q  <= rdv_n;
      miss_q <= miss_n;
    end
  end

  assign rd_valid = rdv_q;
  assign miss     = miss_q;

endmodule

// File: rtl/symtag_mem_chk.sv
module symtag_mem_chk (
  input logic clk,
  input logic rst_n,
  input logic load_mode,
  input logic acc_en,
  input logic acc_sym,
  input logic acc_we,
  input logic rd_valid,
  input logic miss,
  input logic ovf
);

  // R8
  miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(miss && rd_valid));

  // R11
  load_blocks_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_mode |=> (!rd_valid && !miss));

  // R11
  exec_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_mode |=> !ovf);

  // R6
  read_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !load_mode && !acc_we) |=> (rd_valid || miss));

  // R9
  plain_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !load_mode && !acc_we && !acc_sym) |=> (rd_valid && !miss));

  // R7
  write_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !load_mode && acc_we) |=> !rd_valid);

endmodule

bind symtag_mem symtag_mem_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load_mode (load_mode),
  .acc_en    (acc_en),
  .acc_sym   (acc_sym),
  .acc_we    (acc_we),
  .rd_valid  (rd_valid),
  .miss      (miss),
  .ovf       (ovf)
);

// File: tb/tb_symtag_mem.sv
module tb_symtag_mem;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 12;
  localparam int DEPTH  = 64;
  localparam int TAG_W  = 36;
  localparam int AW     = 6;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              load_mode;
  logic              ld_we;
  logic [DATA_W-1:0] ld_wdata;
  logic              ld_label_en;
  logic [TAG_W-1:0]  ld_label;
  logic              ld_var_en;
  logic [TAG_W-1:0]  ld_var_name;
  logic              acc_en;
  logic              acc_sym;
  logic              acc_we;
  logic [AW-1:0]     acc_addr;
  logic [TAG_W-1:0]  acc_name;
  logic [DATA_W-1:0] acc_wdata;
  logic              rd_valid;
  logic [DATA_W-1:0] rd_data;
  logic              miss;
  logic              ovf;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  logic              s_rv, s_ms, s_ov;
  logic [DATA_W-1:0] s_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  symtag_mem dut (.*);

  function automatic logic [DATA_W-1:0] pat1(int i);
    return DATA_W'((i * 37 + 5) & 12'hFFF);
  endfunction
  function automatic logic [DATA_W-1:0] pat2(int i);
    return DATA_W'((i * 91 + 700) & 12'hFFF);
  endfunction
  function automatic logic [TAG_W-1:0] lbl(int i);
    return 36'h100000000 + TAG_W'(i);
  endfunction
  function automatic logic [TAG_W-1:0] vnm(int s, int j);
    return 36'hA00000000 + TAG_W'(s * 256 + j);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ld_we = 0; ld_wdata = '0; ld_label_en = 0; ld_label = '0;
    ld_var_en = 0; ld_var_name = '0;
    acc_en = 0; acc_sym = 0; acc_we = 0; acc_addr = '0;
    acc_name = '0; acc_wdata = '0;
  endtask

  task automatic finish_cycle();
    @(posedge clk); #1;
    s_rv = rd_valid; s_ms = miss; s_ov = ovf; s_rd = rd_data;
    idle_inputs();
  endtask

  task automatic ld_word(input logic [DATA_W-1:0] d, input logic le, input logic [TAG_W-1:0] l);
    @(negedge clk);
    ld_we = 1; ld_wdata = d; ld_label_en = le; ld_label = l;
    finish_cycle();
  endtask

  task automatic ld_var(input logic [TAG_W-1:0] n);
    @(negedge clk);
    ld_var_en = 1; ld_var_name = n;
    finish_cycle();
  endtask

  task automatic acc(input logic sym, input logic we, input logic [AW-1:0] a,
                     input logic [TAG_W-1:0] n, input logic [DATA_W-1:0] wd);
    @(negedge clk);
    acc_en = 1; acc_sym = sym; acc_we = we; acc_addr = a; acc_name = n; acc_wdata = wd;
    finish_cycle();
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk);
    load_mode = m;
    finish_cycle();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 0; load_mode = 0;
    idle_inputs();
    repeat (3) @(posedge clk);
    #1;
    check("R1 rd_valid in reset", rd_valid, 0);
    check("R1 miss in reset", miss, 0);
    check("R1 ovf in reset", ovf, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    check("R1 flags after release", {rd_valid, miss, ovf}, 0);

    // Session 1: the first cycle is the clear cycle; a load request there is ignored (R2)
    @(negedge clk);
    load_mode = 1; ld_we = 1; ld_wdata = 12'hFFF;
    finish_cycle();
    for (int i = 0; i < 20; i++) ld_word(pat1(i), (i % 4) == 0, lbl(i));
    // R4: a label without a program word stores nothing
    @(negedge clk); ld_label_en = 1; ld_label = 36'hBADBADBAD; finish_cycle();
    for (int j = 0; j < 10; j++) begin
      ld_var(vnm(1, j));
      check("R10 no ovf on legal alloc", s_ov, 0);
    end
    // R11: an access during load is ignored
    acc(0, 0, 6'd0, '0, '0);
    check("R11 access ignored in load", {s_rv, s_ms}, 0);

    // R12: access in the very cycle after load_mode falls
    @(negedge clk);
    load_mode = 0; acc_en = 1; acc_sym = 0; acc_addr = 6'd0;
    finish_cycle();
    check("R12 first exec read valid", s_rv, 1);
    check("R12 first exec read data", s_rd, pat1(0));

    // R3/R9 plain reads of every program word; R2 clear cycle wrote nothing at 0
    for (int i = 0; i < 20; i++) begin
      acc(0, 0, AW'(i), '0, '0);
      check("R3 program word", {s_rv, s_rd}, {1'b1, pat1(i)});
    end
    // R6 symbolic reads of labels
    for (int i = 0; i < 20; i += 4) begin
      acc(1, 0, '0, lbl(i), '0);
      check("R6 label read", {s_rv, s_ms, s_rd}, {2'b10, pat1(i)});
    end
    // R8 unlabelled word name and stray label miss
    acc(1, 0, '0, lbl(1), '0);
    check("R8 unlabelled miss", {s_rv, s_ms}, 2'b01);
    acc(1, 0, '0, 36'hBADBADBAD, '0);
    check("R4 label without word misses", {s_rv, s_ms}, 2'b01);
    // R5/R7 variables: write by name, read by address from the top
    for (int j = 0; j < 10; j++) begin
      acc(1, 1, '0, vnm(1, j), DATA_W'(12'h800 + j));
      check("R7 sym write no miss", {s_rv, s_ms}, 0);
    end
    for (int j = 0; j < 10; j++) begin
      acc(0, 0, AW'(DEPTH - 1 - j), '0, '0);
      check("R5 variable placed from top", {s_rv, s_rd}, {1'b1, DATA_W'(12'h800 + j)});
    end
    // R8 symbolic write miss changes no word
    acc(1, 1, '0, 36'h123456789, 12'h0AA);
    check("R8 write miss flag", {s_rv, s_ms}, 2'b01);
    for (int i = 0; i < 20; i++) begin
      acc(0, 0, AW'(i), '0, '0);
      check("R8 miss wrote nothing", s_rd, pat1(i));
    end
    // R9 plain write then symbolic read of label at same word
    acc(0, 1, 6'd8, '0, 12'h3C3);
    acc(1, 0, '0, lbl(8), '0);
    check("R9 plain write seen by name", {s_rv, s_rd}, {1'b1, 12'h3C3});
    // R11 load requests ignored in execution
    acc(0, 1, 6'd20, '0, 12'h111);
    ld_word(12'hABC, 1, 36'h0CAFE0000);
    check("R11 no ovf in exec", s_ov, 0);
    ld_var(36'h0DEAD0000);
    acc(0, 0, 6'd20, '0, '0);
    check("R11 ld_we ignored", s_rd, 12'h111);
    acc(1, 0, '0, 36'h0DEAD0000, '0);
    check("R11 var ignored", s_ms, 1);
    acc(1, 0, '0, 36'h0CAFE0000, '0);
    check("R11 label ignored", s_ms, 1);

    // Session 2: overflow corners
    set_mode(1);
    for (int i = 0; i < 60; i++) ld_word(pat2(i), 1, lbl(100 + i));
    for (int j = 0; j < 4; j++) begin
      ld_var(vnm(2, j));
      check("R10 alloc within room", s_ov, 0);
    end
    ld_var(vnm(2, 4));
    check("R10 alloc overflow", s_ov, 1);
    ld_word(12'h777, 0, '0);
    check("R10 program overflow", s_ov, 1);
    set_mode(0);
    check("R10 ovf single cycle", s_ov, 0);
    acc(1, 0, '0, lbl(0), '0);
    check("R2 old tag cleared", {s_rv, s_ms}, 2'b01);
    acc(1, 0, '0, vnm(2, 4), '0);
    check("R10 refused var has no tag", s_ms, 1);
    acc(1, 0, '0, lbl(159), '0);
    check("R10 last program word intact", {s_rv, s_rd}, {1'b1, pat2(59)});
    for (int j = 0; j < 4; j++) begin
      acc(1, 1, '0, vnm(2, j), DATA_W'(12'h900 + j));
      acc(0, 0, AW'(DEPTH - 1 - j), '0, '0);
      check("R5 session 2 variable slot", s_rd, DATA_W'(12'h900 + j));
    end
    for (int i = 0; i < 60; i++) begin
      acc(1, 0, '0, lbl(100 + i), '0);
      check("R6 session 2 label", {s_rv, s_rd}, {1'b1, pat2(i)});
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule